// File: doc/BRIEF.md
# Reference Time-Base Counter Pair

This block keeps two free-running, read-only time counters that advance from a 25 MHz reference clock from the moment power-on reset is released. One counter reports whole seconds since reset. The other reports the position inside the current second, expressed in 25 MHz ticks. It is refreshed only once every 640 ns, so it advances in jumps of 16 and its four lowest bits always read zero. It wraps at exactly 25,000,000, and the seconds counter steps on that same edge.

Software or a neighbouring block reads the counters through a small strobe-based register port. The read data and an acknowledge appear one cycle after the read strobe. Writes are accepted but change nothing, and the block raises a one-cycle flag for each one. Reads of unmapped addresses return zero and raise a separate flag. The wrap value, the prescaler width and the seconds width are parameters, so the same block can run shortened time scales.

Top module: `tbase_counter_top`

## Requirements
- R1: While `rst_n` is low, all counters, `rd_data`, `rd_ack`, `wr_reject` and `addr_err` are zero. `rst_n` is released through a two-stage synchronizer. The first sub-second update happens on the 18th rising edge after `rst_n` rises.
- R2: The sub-second counter updates exactly once every 2^PRESC_W reference cycles (16 cycles, i.e. 640 ns at 25 MHz) and holds its value in all other cycles.
- R3: Each update adds 2^PRESC_W (16) to the sub-second counter, unless the update is a wrap.
- R4: The low PRESC_W (four) bits of the sub-second counter always read zero, and its value is always below SUB_WRAP (25,000,000).
- R5: An update that would reach SUB_WRAP sets the sub-second counter to zero. The seconds counter increments on that same clock edge and at no other time.
- R6: The seconds counter is SEC_W bits wide (32 by default), increments by one, and wraps silently from all ones to zero.
- R7: A read strobe with address 0 returns the seconds counter, and address 1 returns the sub-second counter, zero-extended to DATA_W. `rd_data` shows the counter value from the cycle in which the strobe is sampled, and `rd_ack` pulses high for one cycle, one cycle after the strobe. `rd_data` holds its value between reads.
- R8: A write strobe to any address leaves both counters unaltered, and `wr_reject` is high in the cycle after each write strobe.
- R9: A read of any address other than 0 or 1 returns zero, and `addr_err` is high in the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 25 MHz reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe (always rejected) |
| acc_addr | input | ADDR_W | Register address: 0 seconds, 1 sub-second |
| rd_data | output | DATA_W | Read data, valid with `rd_ack` |
| rd_ack | output | 1 | Read acknowledge, one cycle after `acc_rd` |
| wr_reject | output | 1 | Pulses one cycle after any write strobe |
| addr_err | output | 1 | Pulses one cycle after a read of an unmapped address |

## Verification
Two functions can land on the same edge: a read sampling the counters, and the wrap that clears the sub-second counter while the seconds counter increments. The bench times reads of both addresses so that they hit the edges around every wrap, including the edge of the wrap itself. A read on that edge must return the pre-wrap pair, and a read one cycle later must return the post-wrap pair. No read may show a torn combination. The expected values come from a cycle-exact model in the bench that counts reference edges from the release of reset. Write strobes are also issued on update edges, and they must leave the modelled sequence unchanged.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // Register map: the address decode of the read port depends on these.
  localparam int unsigned TB_ADDR_SECONDS = 0;
  localparam int unsigned TB_ADDR_SUBSEC  = 1;
  // Stages in the reset-release synchronizer.
  localparam int unsigned TB_SYNC_STAGES  = 2;
endpackage

// File: rtl/tbase_rst_sync.sv
module tbase_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int unsigned PRESC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] div_d;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  // One strobe in the last cycle of each prescaler period.
  assign tick = (div_q == {PRESC_W{1'b1}});
endmodule

// File: rtl/tbase_counters.sv
module tbase_counters #(
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned SUB_WRAP = 25_000_000,
  parameter int unsigned SEC_W    = 32,
  localparam int unsigned SUB_W   = $clog2(SUB_WRAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [SUB_W-1:0] sub_cnt,
  output logic [SEC_W-1:0] sec_cnt
);
  localparam logic [SUB_W-1:0] STEP_V = SUB_W'(1 << PRESC_W);
  localparam logic [SUB_W-1:0] LAST_V = SUB_W'(SUB_WRAP - (1 << PRESC_W));

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             sub_en, sec_en, at_last;

  always_comb begin
    at_last = (sub_q == LAST_V);
    sub_en  = tick;
    sec_en  = tick && at_last;
    sub_d   = at_last ? '0 : (sub_q + STEP_V);
    sec_d   = sec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (sub_en) begin
      sub_q <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_en) begin
      sec_q <= sec_d;
    end
  end

  assign sub_cnt = sub_q;
  assign sec_cnt = sec_q;
endmodule

// File: rtl/tbase_regif.sv
module tbase_regif
  import tbase_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SUB_W  = 25,
  parameter int unsigned SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SUB_W-1:0]  sub_cnt,
  input  logic [SEC_W-1:0]  sec_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic              wr_reject,
  output logic              addr_err
);
  logic [DATA_W-1:0] data_q, data_d, sel_val;
  logic              ack_q, ack_d;
  logic              rej_q, rej_d;
  logic              err_q, err_d;
  logic              unmapped;

  always_comb begin
    sel_val  = '0;
    unmapped = 1'b0;
    if (acc_addr == ADDR_W'(TB_ADDR_SECONDS)) begin
      sel_val = DATA_W'(sec_cnt);
    end else if (acc_addr == ADDR_W'(TB_ADDR_SUBSEC)) begin
      sel_val = DATA_W'(sub_cnt);
    end else begin
      unmapped = 1'b1;
    end
    data_d = acc_rd ? sel_val : data_q;
    ack_d  = acc_rd;
    err_d  = acc_rd && unmapped;
    rej_d  = acc_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ack_q  <= 1'b0;
      rej_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      ack_q  <= ack_d;
      rej_q  <= rej_d;
      err_q  <= err_d;
    end
  end

  assign rd_data   = data_q;
  assign rd_ack    = ack_q;
  assign wr_reject = rej_q;
  assign addr_err  = err_q;
endmodule

// File: rtl/tbase_counter_top.sv
module tbase_counter_top
  import tbase_pkg::*;
#(
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned SUB_WRAP = 25_000_000,
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic              wr_reject,
  output logic              addr_err
);
  localparam int unsigned SUB_W = $clog2(SUB_WRAP);

  logic             rst_sync_n;
  logic             tick;
  logic [SUB_W-1:0] sub_cnt;
  logic [SEC_W-1:0] sec_cnt;

  tbase_rst_sync #(.STAGES(TB_SYNC_STAGES)) u_rst (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tbase_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk_ref),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  tbase_counters #(
    .PRESC_W  (PRESC_W),
    .SUB_WRAP (SUB_WRAP),
    .SEC_W    (SEC_W)
  ) u_cnt (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .sub_cnt (sub_cnt),
    .sec_cnt (sec_cnt)
  );

  tbase_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SUB_W  (SUB_W),
    .SEC_W  (SEC_W)
  ) u_regif (
    .clk       (clk_ref),
    .rst_n     (rst_sync_n),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .sub_cnt   (sub_cnt),
    .sec_cnt   (sec_cnt),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack),
    .wr_reject (wr_reject),
    .addr_err  (addr_err)
  );
endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned SUB_WRAP = 25_000_000,
  parameter int unsigned SEC_W    = 32,
  localparam int unsigned SUB_W   = $clog2(SUB_WRAP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SUB_W-1:0] sub,
  input logic [SEC_W-1:0] sec,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic             rd_ack,
  input logic             wr_reject
);
  localparam logic [SUB_W-1:0] STEP_V = SUB_W'(1 << PRESC_W);
  localparam logic [SUB_W-1:0] LAST_V = SUB_W'(SUB_WRAP - (1 << PRESC_W));
  localparam logic [SUB_W-1:0] WRAP_V = SUB_W'(SUB_WRAP);

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sub) |-> ((sub == $past(sub) + STEP_V) || (sub == '0 && $past(sub) == LAST_V))); // R3
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub < WRAP_V) && (sub[PRESC_W-1:0] == '0)); // R4
  AST_SEC_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec) |-> (sub == '0 && $past(sub) == LAST_V)); // R5
  AST_SEC_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec) |-> (sec == $past(sec) + 1'b1)); // R6
  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_ack); // R7
  AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> wr_reject); // R8
endmodule

bind tbase_counter_top tbase_counter_chk #(
  .PRESC_W  (PRESC_W),
  .SUB_WRAP (SUB_WRAP),
  .SEC_W    (SEC_W)
) u_chk (
  .clk       (clk_ref),
  .rst_n     (rst_sync_n),
  .sub       (sub_cnt),
  .sec       (sec_cnt),
  .acc_rd    (acc_rd),
  .acc_wr    (acc_wr),
  .rd_ack    (rd_ack),
  .wr_reject (wr_reject)
);

// File: tb/tbase_counter_top_tb_top.sv
module tbase_counter_top_tb_top;
  localparam int PRESC_W  = 4;
  localparam int STEP     = 1 << PRESC_W;
  localparam int SUB_WRAP = 320;
  localparam int SEC_W    = 4;
  localparam int FIRST_UPD = 18;   // edge number of the first update after rst_n rises

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_addr = 2'd0;
  logic [31:0] rd_data;
  logic        rd_ack, wr_reject, addr_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  tbase_counter_top #(
    .PRESC_W(PRESC_W), .SUB_WRAP(SUB_WRAP), .SEC_W(SEC_W), .ADDR_W(2), .DATA_W(32)
  ) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .rd_data(rd_data), .rd_ack(rd_ack),
    .wr_reject(wr_reject), .addr_err(addr_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, cyc);
    end
  endtask

  // Number of updates that have happened on edges up to and including edge k.
  function automatic int updates(input int k);
    return (k >= FIRST_UPD) ? ((k - FIRST_UPD) / STEP + 1) : 0;
  endfunction
  function automatic int exp_sub(input int k);
    return (updates(k) * STEP) % SUB_WRAP;
  endfunction
  function automatic int exp_sec(input int k);
    return ((updates(k) * STEP) / SUB_WRAP) % (1 << SEC_W);
  endfunction

  // Starts and ends at a falling edge; consumes one rising edge.
  // The data is the state before that edge, i.e. after edge (cyc-1).
  task automatic do_read(input logic [1:0] a, output int d, output bit ack, output bit err);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
    d = int'(rd_data); ack = rd_ack; err = addr_err;
  endtask

  task automatic t_reset;
    int d; bit ack, err;
    repeat (4) @(negedge clk);
    check(rd_data == 0, "R1 rd_data in reset", rd_data, 0);
    check(rd_ack == 0 && wr_reject == 0 && addr_err == 0, "R1 flags in reset",
          {rd_ack, wr_reject, addr_err}, 0);
    rst_n = 1'b1;
    for (int i = 1; i <= 18; i++) begin
      do_read(2'd1, d, ack, err);
      check(d == 0, "R1 sub before first update", d, 0);
    end
    do_read(2'd1, d, ack, err);
    check(d == STEP, "R1 first update on edge 18", d, STEP);
    check(ack == 1'b1, "R7 rd_ack after read", ack, 1);
  endtask

  task automatic t_sub_sequence;
    int d; bit ack, err;
    for (int i = 0; i < 200; i++) begin
      do_read(2'd1, d, ack, err);
      check(d == exp_sub(cyc - 1), "R2 R3 sub-second sequence", d, exp_sub(cyc - 1));
      check((d % STEP) == 0 && d < SUB_WRAP, "R4 low bits zero and below wrap", d, exp_sub(cyc - 1));
    end
    @(negedge clk);
    check(rd_ack == 1'b0, "R7 rd_ack single pulse", rd_ack, 0);
    check(int'(rd_data) == d, "R7 rd_data holds between reads", rd_data, d);
  endtask

  // Alternate addresses so reads fall on, before and after each wrap edge.
  task automatic t_wrap_coherent;
    int d; bit ack, err; bit seen_wrap;
    int prev_sec;
    seen_wrap = 1'b0;
    prev_sec = exp_sec(cyc);
    for (int i = 0; i < 700; i++) begin
      if (i % 2 == 0) begin
        do_read(2'd0, d, ack, err);
        check(d == exp_sec(cyc - 1), "R5 seconds around wrap", d, exp_sec(cyc - 1));
        if (d != prev_sec) seen_wrap = 1'b1;
        prev_sec = d;
      end else begin
        do_read(2'd1, d, ack, err);
        check(d == exp_sub(cyc - 1), "R5 sub-second around wrap", d, exp_sub(cyc - 1));
      end
    end
    check(seen_wrap, "R5 wrap observed", seen_wrap, 1);
  endtask

  task automatic t_write_ignored;
    int d; bit ack, err;
    for (int i = 0; i < 40; i++) begin
      acc_wr = 1'b1; acc_addr = 2'(i % 2);
      @(negedge clk);
      acc_wr = 1'b0;
      check(wr_reject == 1'b1, "R8 wr_reject after write", wr_reject, 1);
      do_read(2'(i % 2), d, ack, err);
      if (i % 2 == 0)
        check(d == exp_sec(cyc - 1), "R8 seconds unaltered by write", d, exp_sec(cyc - 1));
      else
        check(d == exp_sub(cyc - 1), "R8 sub-second unaltered by write", d, exp_sub(cyc - 1));
      check(wr_reject == 1'b0, "R8 wr_reject clears", wr_reject, 0);
    end
  endtask

  task automatic t_unmapped;
    int d; bit ack, err;
    for (int a = 2; a <= 3; a++) begin
      do_read(2'(a), d, ack, err);
      check(d == 0, "R9 unmapped reads zero", d, 0);
      check(err == 1'b1 && ack == 1'b1, "R9 addr_err on unmapped read", {err, ack}, 3);
    end
    do_read(2'd1, d, ack, err);
    check(err == 1'b0, "R9 no addr_err on mapped read", err, 0);
  endtask

  task automatic t_sec_wrap;
    int d; bit ack, err; bit seen_roll; int prev;
    seen_roll = 1'b0;
    prev = exp_sec(cyc);
    while (updates(cyc) * STEP < (1 << SEC_W) * SUB_WRAP + SUB_WRAP) begin
      do_read(2'd0, d, ack, err);
      check(d == exp_sec(cyc - 1), "R6 seconds value", d, exp_sec(cyc - 1));
      if (prev == (1 << SEC_W) - 1 && d == 0) seen_roll = 1'b1;
      prev = d;
    end
    check(seen_roll, "R6 seconds wrap to zero", seen_roll, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sub_sequence();
    t_wrap_coherent();
    t_write_ignored();
    t_unmapped();
    t_sec_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule